// File: doc/BRIEF.md
# Reset Source Controller with Power-up Delay

This block gathers every reset request of a device into a single active-high device reset and keeps a record of what caused it. The requests are power-on, a main brown-out detector, a low-power brown-out detector, an external active-low clear pin, two watchdog conditions (time-out and window violation), a software reset instruction, stack overflow, stack underflow and the exit from programming mode. Configuration inputs decide which of them count. Voltage sensing, the pin pull-up and watchdog timing are outside the block; they arrive as digital levels. The block never drives the clear pin. It only samples it.

The reset output rises combinationally as soon as any enabled request is present. It falls on a system clock edge once every request has gone away. After power-on, a brown-out or a programming-mode exit, an optional power-up hold keeps the reset high for a parameterised number of slow-clock ticks. The slow clock is given as a one-cycle enable pulse, `slow_tick`, in the system clock domain. The clear pin is synchronised with two flops and then filtered, so that it only acts once it has been seen low on a parameterised number of consecutive slow ticks.

A seven-bit cause register holds the reset causes. It can be read, and software may overwrite it at any time. The sequencer has four states:
- `ST_POWER`: held by power-on or brown-out.
- `ST_DELAY`: power-up count in progress.
- `ST_HOLD`: waiting for all requests to drop.
- `ST_RUN`: device released.

Its transitions are named as follows:
- `power_release`: ST_POWER to ST_DELAY, or to ST_HOLD when the timer is off.
- `delay_done`: ST_DELAY to ST_HOLD.
- `brownout_hit`: any state to ST_POWER when a brown-out or programming exit appears.
- `request_hit`: ST_RUN to ST_HOLD.
- `all_clear`: ST_HOLD to ST_RUN.

Top module: `rst_src_ctrl`

## Requirements
- R1: The brown-out condition is `bor_req | (lpbor_req & cfg_lpbor_en)`. While it is present, `dev_reset` is 1 and cause bit 0 (brown-out, active low) is written 0. With `cfg_lpbor_en` = 0, `lpbor_req` has no effect.
- R2: The clear pin is enabled when `cfg_lvp` = 1, or when `cfg_lvp` = 0 and `cfg_pin_en` = 1. With both at 0, a low pin neither resets the device nor changes cause bit 1.
- R3: An enabled pin that is seen low on FILT_TICKS consecutive slow ticks, after the two-flop synchroniser, asserts `dev_reset` and writes cause bit 1 (pin, active low) to 0. A low pulse that spans fewer ticks is ignored.
- R4: `sw_reset` asserts `dev_reset` and writes cause bit 2 (software, active low) to 0.
- R5: `wdt_timeout` or `wdt_window` asserts `dev_reset` and writes cause bit 3 (watchdog, active low) to 0. Cause bit 4 becomes 1 for a window violation and 0 for a time-out.
- R6: With `cfg_stack_en` = 1, `stk_ovf` sets cause bit 5 to 1 and `stk_unf` sets cause bit 6 to 1, and each asserts `dev_reset`. With `cfg_stack_en` = 0, both are ignored.
- R7: With `cfg_pwrt_n` = 0, after power-on and brown-out have both been released, `dev_reset` stays 1 for PWRT_CYCLES (default 2048) slow ticks. With `cfg_pwrt_n` = 1, it drops within two clock edges.
- R8: A `prog_exit` pulse acts like power-on: cause returns to 0x0E, and the power-up hold of R7 follows.
- R9: While `por_req` is 1, `dev_reset` is 1 and cause reads 0x0E (bit 0 = 0, bits 1..3 = 1, bits 4..6 = 0).
- R10: `dev_reset` is 1 in the same cycle that any enabled request is 1. It falls only on a clock edge, after the requests have been absent for one edge.
- R11: `cause_wr_en` loads `cause_wr_data` into the cause register. If a reset event happens in the same cycle, the event's own bits take the event's value and the other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high, asynchronous |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock period |
| bor_req | input | 1 | Main brown-out request |
| lpbor_req | input | 1 | Low-power brown-out request |
| clr_pin_n | input | 1 | External clear pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog time-out request |
| wdt_window | input | 1 | Watchdog window-violation request |
| sw_reset | input | 1 | Software reset instruction |
| stk_ovf | input | 1 | Stack overflow request |
| stk_unf | input | 1 | Stack underflow request |
| prog_exit | input | 1 | Programming-mode exit pulse |
| cfg_lpbor_en | input | 1 | Enables the low-power brown-out request |
| cfg_pin_en | input | 1 | Pin enable, used when cfg_lvp is 0 |
| cfg_lvp | input | 1 | Low-voltage programming setting; 1 forces the pin on |
| cfg_stack_en | input | 1 | Enables the stack resets |
| cfg_pwrt_n | input | 1 | 0 enables the power-up hold |
| cause_wr_en | input | 1 | Software write strobe for the cause register |
| cause_wr_data | input | 7 | Software write data |
| cause | output | 7 | Cause register |
| dev_reset | output | 1 | Combined device reset, active high |

## Verification
A software write to the cause register and a reset event can land in the same clock cycle. The bench provokes this by raising `cause_wr_en` and `sw_reset` in the same cycle. It then judges the merged result: the written value should appear, except that the software flag reads 0. A second coincidence is a brown-out arriving during the power-up count. The programming-exit test shows the power-up count restarting from a new power event, and the bench checks that the release comes only after the full tick count.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int CAUSE_W   = 7;
    localparam int B_BOR_N   = 0;
    localparam int B_PIN_N   = 1;
    localparam int B_SWR_N   = 2;
    localparam int B_WDT_N   = 3;
    localparam int B_WDT_WIN = 4;
    localparam int B_OVF     = 5;
    localparam int B_UNF     = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_DEFAULT = 7'b000_1110;

    typedef enum logic [1:0] {
        ST_POWER = 2'd0,
        ST_DELAY = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/rsc_pin_filter.sv
module rsc_pin_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic por_req,
    input  logic slow_tick,
    input  logic pin_n,
    output logic pin_low
);
    localparam int CW = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;

    logic          sync0, sync1;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            sync0 <= 1'b1;
            sync1 <= 1'b1;
        end else begin
            sync0 <= pin_n;
            sync1 <= sync0;
        end
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            low_cnt <= '0;
            pin_low <= 1'b0;
        end else if (sync1) begin
            low_cnt <= '0;
            pin_low <= 1'b0;
        end else if (slow_tick && !pin_low) begin
            if (low_cnt == CW'(FILT_TICKS - 1)) begin
                pin_low <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsc_sequencer.sv
module rsc_sequencer
    import rsc_pkg::*;
#(
    parameter int PWRT_CYCLES = 2048
) (
    input  logic clk,
    input  logic por_req,
    input  logic slow_tick,
    input  logic bor_any,
    input  logic prog_exit,
    input  logic other_req,
    input  logic pwrt_en,
    output logic held
);
    localparam int DW = (PWRT_CYCLES > 1) ? $clog2(PWRT_CYCLES) : 1;

    seq_state_t    state, state_nx;
    logic [DW-1:0] dly_cnt;
    logic          dly_last;

    assign dly_last = slow_tick && (dly_cnt == DW'(PWRT_CYCLES - 1));

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            state <= ST_POWER;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            dly_cnt <= '0;
        end else if (state != ST_DELAY || bor_any || prog_exit) begin
            dly_cnt <= '0;
        end else if (slow_tick) begin
            dly_cnt <= dly_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        if (bor_any || prog_exit) begin
            state_nx = ST_POWER;                               // brownout_hit
        end else begin
            unique case (state)
                ST_POWER: state_nx = pwrt_en ? ST_DELAY : ST_HOLD; // power_release
                ST_DELAY: if (dly_last) state_nx = ST_HOLD;        // delay_done
                ST_HOLD:  if (!other_req) state_nx = ST_RUN;       // all_clear
                ST_RUN:   if (other_req) state_nx = ST_HOLD;       // request_hit
                default:  state_nx = ST_POWER;
            endcase
        end
    end

    always_comb begin
        held = (state != ST_RUN);
    end
endmodule

// File: rtl/rsc_cause_reg.sv
module rsc_cause_reg
    import rsc_pkg::*;
(
    input  logic               clk,
    input  logic               por_req,
    input  logic               prog_exit,
    input  logic               bor_ev,
    input  logic               pin_ev,
    input  logic               swr_ev,
    input  logic               wdt_to_ev,
    input  logic               wdt_win_ev,
    input  logic               ovf_ev,
    input  logic               unf_ev,
    input  logic               wr_en,
    input  logic [CAUSE_W-1:0] wr_data,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] merged;

    always_comb begin
        merged = wr_en ? wr_data : cause;
        if (bor_ev) merged[B_BOR_N] = 1'b0;
        if (pin_ev) merged[B_PIN_N] = 1'b0;
        if (swr_ev) merged[B_SWR_N] = 1'b0;
        if (wdt_to_ev || wdt_win_ev) begin
            merged[B_WDT_N]   = 1'b0;
            merged[B_WDT_WIN] = wdt_win_ev;
        end
        if (ovf_ev) merged[B_OVF] = 1'b1;
        if (unf_ev) merged[B_UNF] = 1'b1;
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            cause <= CAUSE_DEFAULT;
        end else if (prog_exit) begin
            cause <= CAUSE_DEFAULT;
        end else begin
            cause <= merged;
        end
    end
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rsc_pkg::*;
#(
    parameter int FILT_TICKS  = 4,
    parameter int PWRT_CYCLES = 2048
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               slow_tick,
    input  logic               bor_req,
    input  logic               lpbor_req,
    input  logic               clr_pin_n,
    input  logic               wdt_timeout,
    input  logic               wdt_window,
    input  logic               sw_reset,
    input  logic               stk_ovf,
    input  logic               stk_unf,
    input  logic               prog_exit,
    input  logic               cfg_lpbor_en,
    input  logic               cfg_pin_en,
    input  logic               cfg_lvp,
    input  logic               cfg_stack_en,
    input  logic               cfg_pwrt_n,
    input  logic               cause_wr_en,
    input  logic [CAUSE_W-1:0] cause_wr_data,
    output logic [CAUSE_W-1:0] cause,
    output logic               dev_reset
);
    logic pin_low, pin_on, pin_ev, bor_any, ovf_ev, unf_ev, other_req, held;

    assign pin_on    = cfg_lvp | cfg_pin_en;
    assign pin_ev    = pin_on & pin_low;
    assign bor_any   = bor_req | (lpbor_req & cfg_lpbor_en);
    assign ovf_ev    = stk_ovf & cfg_stack_en;
    assign unf_ev    = stk_unf & cfg_stack_en;
    assign other_req = pin_ev | sw_reset | wdt_timeout | wdt_window | ovf_ev | unf_ev;

    rsc_pin_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk       (clk),
        .por_req   (por_req),
        .slow_tick (slow_tick),
        .pin_n     (clr_pin_n),
        .pin_low   (pin_low)
    );

    rsc_sequencer #(.PWRT_CYCLES(PWRT_CYCLES)) u_seq (
        .clk       (clk),
        .por_req   (por_req),
        .slow_tick (slow_tick),
        .bor_any   (bor_any),
        .prog_exit (prog_exit),
        .other_req (other_req),
        .pwrt_en   (~cfg_pwrt_n),
        .held      (held)
    );

    rsc_cause_reg u_cause (
        .clk        (clk),
        .por_req    (por_req),
        .prog_exit  (prog_exit),
        .bor_ev     (bor_any),
        .pin_ev     (pin_ev),
        .swr_ev     (sw_reset),
        .wdt_to_ev  (wdt_timeout),
        .wdt_win_ev (wdt_window),
        .ovf_ev     (ovf_ev),
        .unf_ev     (unf_ev),
        .wr_en      (cause_wr_en),
        .wr_data    (cause_wr_data),
        .cause      (cause)
    );

    always_comb begin
        dev_reset = por_req | bor_any | prog_exit | other_req | held;
    end
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker (
    input logic       clk,
    input logic       por_req,
    input logic       bor_req,
    input logic       sw_reset,
    input logic       wdt_timeout,
    input logic       wdt_window,
    input logic       stk_ovf,
    input logic       cfg_stack_en,
    input logic       cfg_pin_en,
    input logic       cfg_lvp,
    input logic       prog_exit,
    input logic       cause_wr_en,
    input logic [6:0] cause,
    input logic       dev_reset
);
    // R1
    bor_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        bor_req |=> !cause[0]);

    // R2
    pin_off_chk: assert property (@(posedge clk) disable iff (por_req)
        (!cfg_lvp && !cfg_pin_en && !cause_wr_en && !prog_exit) |=> $stable(cause[1]));

    // R4
    swr_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        (sw_reset && !prog_exit) |=> !cause[2]);

    // R5
    wdt_win_chk: assert property (@(posedge clk) disable iff (por_req)
        (wdt_window && !wdt_timeout && !prog_exit) |=> (!cause[3] && cause[4]));

    // R6
    ovf_flag_chk: assert property (@(posedge clk) disable iff (por_req)
        (stk_ovf && cfg_stack_en && !prog_exit) |=> cause[5]);

    // R8
    prog_default_chk: assert property (@(posedge clk) disable iff (por_req)
        prog_exit |=> (cause == 7'h0E));

    // R10
    async_assert_chk: assert property (@(posedge clk) disable iff (por_req)
        sw_reset |-> dev_reset);

    // R10
    sync_release_chk: assert property (@(posedge clk) disable iff (por_req)
        $fell(dev_reset) |-> !$past(sw_reset));
endmodule

bind rst_src_ctrl rsc_checker u_chk (
    .clk          (clk),
    .por_req      (por_req),
    .bor_req      (bor_req),
    .sw_reset     (sw_reset),
    .wdt_timeout  (wdt_timeout),
    .wdt_window   (wdt_window),
    .stk_ovf      (stk_ovf),
    .cfg_stack_en (cfg_stack_en),
    .cfg_pin_en   (cfg_pin_en),
    .cfg_lvp      (cfg_lvp),
    .prog_exit    (prog_exit),
    .cause_wr_en  (cause_wr_en),
    .cause        (cause),
    .dev_reset    (dev_reset)
);

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_req = 1'b1, slow_tick = 1'b0;
    logic       bor_req = 0, lpbor_req = 0, clr_pin_n = 1;
    logic       wdt_timeout = 0, wdt_window = 0, sw_reset = 0;
    logic       stk_ovf = 0, stk_unf = 0, prog_exit = 0;
    logic       cfg_lpbor_en = 0, cfg_pin_en = 1, cfg_lvp = 0;
    logic       cfg_stack_en = 0, cfg_pwrt_n = 1;
    logic       cause_wr_en = 0;
    logic [6:0] cause_wr_data = '0;
    logic [6:0] cause;
    logic       dev_reset;
    int         n_checks = 0, n_fails = 0;
    int         tick_count = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    rst_src_ctrl u_rst_src_ctrl (
        .clk(clk), .por_req(por_req), .slow_tick(slow_tick),
        .bor_req(bor_req), .lpbor_req(lpbor_req), .clr_pin_n(clr_pin_n),
        .wdt_timeout(wdt_timeout), .wdt_window(wdt_window), .sw_reset(sw_reset),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf), .prog_exit(prog_exit),
        .cfg_lpbor_en(cfg_lpbor_en), .cfg_pin_en(cfg_pin_en), .cfg_lvp(cfg_lvp),
        .cfg_stack_en(cfg_stack_en), .cfg_pwrt_n(cfg_pwrt_n),
        .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
        .cause(cause), .dev_reset(dev_reset)
    );

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 slow_tick = 1'b1;
            tick_count++;
            @(posedge clk);
            #1 slow_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic write_cause(input logic [6:0] v);
        cause_wr_en = 1; cause_wr_data = v;
        step(1);
        cause_wr_en = 0;
    endtask

    task automatic wait_ticks(input int n);
        int start = tick_count;
        while (tick_count - start < n) step(1);
    endtask

    task automatic t_power_on();
        step(1);
        sample();
        check("R9 reset during por", dev_reset, 1);
        check("R9 cause default", cause, 7'h0E);
        @(posedge clk); #1 por_req = 0;
        step(4); sample();
        check("R7 no pwrt release", dev_reset, 0);
    endtask

    task automatic t_write_and_sw();
        write_cause(7'h7F); sample();
        check("R11 plain write", cause, 7'h7F);
        sw_reset = 1; sample();
        check("R10 async assert sw", dev_reset, 1);
        step(1); sw_reset = 0;
        sample();
        check("R4 sw flag", cause, 7'h7B);
        step(2); sample();
        check("R10 sync release", dev_reset, 0);
    endtask

    task automatic t_collision();
        cause_wr_en = 1; cause_wr_data = 7'h7F; sw_reset = 1;
        step(1);
        cause_wr_en = 0; sw_reset = 0;
        sample();
        check("R11 write+event merge", cause, 7'h7B);
        step(3);
    endtask

    task automatic t_wdt();
        write_cause(7'h7F);
        wdt_window = 1; sample();
        check("R5 wdt reset", dev_reset, 1);
        step(1); wdt_window = 0; sample();
        check("R5 window flags", cause, 7'h77);
        step(3);
        write_cause(7'h7F);
        wdt_timeout = 1; step(1); wdt_timeout = 0; sample();
        check("R5 timeout flags", cause, 7'h67);
        step(3);
    endtask

    task automatic t_stack();
        write_cause(7'h0E);
        cfg_stack_en = 0; stk_ovf = 1; sample();
        check("R6 ovf ignored reset", dev_reset, 0);
        step(1); stk_ovf = 0; sample();
        check("R6 ovf ignored flag", cause, 7'h0E);
        cfg_stack_en = 1; stk_ovf = 1; sample();
        check("R6 ovf reset", dev_reset, 1);
        step(1); stk_ovf = 0; sample();
        check("R6 ovf flag", cause, 7'h2E);
        stk_unf = 1; step(1); stk_unf = 0; sample();
        check("R6 unf flag", cause, 7'h6E);
        step(3);
    endtask

    task automatic t_lpbor();
        write_cause(7'h7F);
        cfg_lpbor_en = 0; lpbor_req = 1; step(1); sample();
        check("R1 lpbor disabled reset", dev_reset, 0);
        lpbor_req = 0; step(1); sample();
        check("R1 lpbor disabled flag", cause, 7'h7F);
        cfg_lpbor_en = 1; lpbor_req = 1; sample();
        check("R1 lpbor reset", dev_reset, 1);
        step(2); lpbor_req = 0; sample();
        check("R1 bor flag", cause, 7'h7E);
        step(3); sample();
        check("R1 release", dev_reset, 0);
    endtask

    task automatic t_pin();
        write_cause(7'h7F);
        cfg_lvp = 0; cfg_pin_en = 0;
        clr_pin_n = 0; step(40); sample();
        check("R2 pin disabled reset", dev_reset, 0);
        check("R2 pin disabled flag", cause, 7'h7F);
        clr_pin_n = 1; step(6);
        cfg_lvp = 1;
        clr_pin_n = 0; step(8); clr_pin_n = 1; step(8); sample();
        check("R3 short pulse reset", dev_reset, 0);
        check("R3 short pulse flag", cause, 7'h7F);
        clr_pin_n = 0; step(40); sample();
        check("R3 long low reset", dev_reset, 1);
        check("R3 pin flag", cause, 7'h7D);
        clr_pin_n = 1; step(8); sample();
        check("R3 pin release", dev_reset, 0);
        cfg_lvp = 0; cfg_pin_en = 1;
    endtask

    task automatic t_pwrt();
        cfg_pwrt_n = 0;
        write_cause(7'h7F);
        bor_req = 1; step(3); bor_req = 0;
        sample();
        check("R1 bor flag pwrt", cause, 7'h7E);
        wait_ticks(1000); sample();
        check("R7 held mid", dev_reset, 1);
        bor_req = 1; step(2); bor_req = 0;
        wait_ticks(2040); sample();
        check("R7 held after restart", dev_reset, 1);
        wait_ticks(12); sample();
        check("R7 released", dev_reset, 0);
    endtask

    task automatic t_prog_exit();
        write_cause(7'h7F);
        prog_exit = 1; sample();
        check("R8 async assert", dev_reset, 1);
        step(1); prog_exit = 0; sample();
        check("R8 cause default", cause, 7'h0E);
        wait_ticks(2040); sample();
        check("R8 held", dev_reset, 1);
        wait_ticks(12); sample();
        check("R8 released", dev_reset, 0);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_checks++; n_fails++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
            begin
                t_power_on();
                t_write_and_sw();
                t_collision();
                t_wdt();
                t_stack();
                t_lpbor();
                t_pin();
                t_pwrt();
                t_prog_exit();
                done = 1;
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule